// File: doc/BRIEF.md
# Halt and resume group propagator

This block spreads halt and resume events across a set of harts and external trigger lines. Every hart, every incoming trigger and every outgoing trigger holds two group numbers, one for halting and one for resuming, which are written and read back through a small configuration port. The block watches each hart's halted and running status and the incoming trigger pulses. When a member of a nonzero group halts or resumes, the other harts of that group receive a one-clock request and the outgoing triggers of that group pulse for one clock. Group 0 never propagates anything, so its members behave as if grouping did not exist.

Halt events come from the rising edge of a hart's halted signal, or from an incoming trigger that is high in a cycle. Halt propagation goes out in the next cycle, without conditions. Resume propagation is gated per group by a two-state machine. In RG_IDLE, a resume event fires at once if no abstract command is running. If a command is running, the machine goes RG_IDLE to RG_HOLD and absorbs further events. In RG_HOLD it fires and returns to RG_IDLE in the first cycle the command-busy input is low. Harts that are halting or already running get no resume request. A hart that halts or resumes because of a propagated request produces a new edge, and that edge is handled like any other.

Top module: `halt_resume_grouper`

## Requirements
- R1: While and after reset, halt_req, resume_req and trig_out are all zero, and every group assignment reads back as 0.
- R2: A rising edge of hart_halted[s] sampled at a clock edge makes halt_req pulse for exactly one cycle after that edge, on every hart whose halt group equals the nonzero halt group of hart s, hart s included, and on no other hart.
- R3: An incoming trigger that is high at a clock edge acts like a halt event of its halt group and like a resume event of its resume group.
- R4: A rising edge of hart_running[s] in nonzero resume group g, with abs_busy low, makes resume_req pulse for one cycle after that edge on the members of g.
- R5: While abs_busy is high, resume requests of a group are held back. In the first cycle with abs_busy low, they are released and become visible one clock later, as one pulse.
- R6: A hart whose hart_halting or hart_running input is high in the dispatch cycle receives no resume request.
- R7: Members of group 0 neither cause nor receive propagated requests.
- R8: trig_out[t] pulses for one cycle together with the halt requests of its halt group, and together with the resume dispatch of its resume group.
- R9: Writing a group assignment never produces a halt or resume request, even if other members of the target group are already halted or running.
- R10: The configuration address is cfg_kind (0 = halt group, 1 = resume group) and cfg_idx. Indices 0 to 3 are harts, 4 to 5 are incoming triggers and 6 to 7 are outgoing triggers. cfg_rdata shows the stored value of the addressed entry in the same cycle.
- R11: A halted or running level held high produces only one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low debug-module reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 selects halt group, 1 selects resume group |
| cfg_idx | input | 3 | Member index (harts, then incoming, then outgoing triggers) |
| cfg_wdata | input | 2 | Group number to store |
| cfg_rdata | output | 2 | Group number of the addressed member |
| hart_halted | input | 4 | Halted status per hart |
| hart_running | input | 4 | Running status per hart |
| hart_halting | input | 4 | Hart is in the middle of halting |
| trig_in | input | 2 | Incoming external trigger pulses |
| abs_busy | input | 1 | An abstract command is in progress |
| halt_req | output | 4 | One-cycle halt request per hart |
| resume_req | output | 4 | One-cycle resume request per hart |
| trig_out | output | 2 | One-cycle outgoing trigger pulses |

## Verification
The hardest situation to reach is a resume event that arrives while a command is busy and must survive in RG_HOLD until abs_busy drops. An incoming trigger fires under a held busy level, the outputs are watched for several quiet cycles, and then busy is released at a known cycle. The other hard part is covering every grouping. For this, every one of the 256 halt-group and 256 resume-group assignments of the four harts is programmed through the port. Each hart in turn is then used as the event source, with a halting pattern that changes from run to run.

// File: rtl/hrg_pkg.sv
package hrg_pkg;
    typedef enum logic [0:0] {
        RG_IDLE = 1'b0,
        RG_HOLD = 1'b1
    } rgate_state_e;

    typedef enum logic [0:0] {
        KIND_HALT   = 1'b0,
        KIND_RESUME = 1'b1
    } grp_kind_e;
endpackage

// File: rtl/hrg_rise.sv
module hrg_rise #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else begin
            sig_q <= sig;
        end
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/hrg_cfg_regs.sv
module hrg_cfg_regs
    import hrg_pkg::*;
#(
    parameter int N_MEM = 8,
    parameter int GW    = 2,
    parameter int IW    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic                      kind,
    input  logic [IW-1:0]             idx,
    input  logic [GW-1:0]             wdata,
    output logic [GW-1:0]             rdata,
    output logic [N_MEM-1:0][GW-1:0]  hgrp_o,
    output logic [N_MEM-1:0][GW-1:0]  rgrp_o
);
    logic [N_MEM-1:0][GW-1:0] hgrp_q;
    logic [N_MEM-1:0][GW-1:0] rgrp_q;
    logic                     sel_ok;

    assign sel_ok = (32'(idx) < N_MEM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hgrp_q <= '0;
            rgrp_q <= '0;
        end else if (we && sel_ok) begin
            if (grp_kind_e'(kind) == KIND_RESUME) begin
                rgrp_q[idx] <= wdata;
            end else begin
                hgrp_q[idx] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ok) begin
            rdata = (grp_kind_e'(kind) == KIND_RESUME) ? rgrp_q[idx] : hgrp_q[idx];
        end
    end

    assign hgrp_o = hgrp_q;
    assign rgrp_o = rgrp_q;
endmodule

// File: rtl/hrg_resume_gate.sv
module hrg_resume_gate
    import hrg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic busy,
    output logic fire
);
    rgate_state_e state_q;
    rgate_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            RG_IDLE: begin
                if (evt) begin
                    if (busy) begin
                        state_d = RG_HOLD;
                    end else begin
                        fire = 1'b1;
                    end
                end
            end
            RG_HOLD: begin
                if (!busy) begin
                    fire    = 1'b1;
                    state_d = RG_IDLE;
                end
            end
            default: state_d = RG_IDLE;
        endcase
    end
endmodule

// File: rtl/halt_resume_grouper.sv
module halt_resume_grouper #(
    parameter int N_GROUPS   = 4,
    parameter int N_HARTS    = 4,
    parameter int N_TRIG_IN  = 2,
    parameter int N_TRIG_OUT = 2,
    localparam int GW    = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1,
    localparam int N_MEM = N_HARTS + N_TRIG_IN + N_TRIG_OUT,
    localparam int IW    = (N_MEM > 1) ? $clog2(N_MEM) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_kind,
    input  logic [IW-1:0]         cfg_idx,
    input  logic [GW-1:0]         cfg_wdata,
    output logic [GW-1:0]         cfg_rdata,
    input  logic [N_HARTS-1:0]    hart_halted,
    input  logic [N_HARTS-1:0]    hart_running,
    input  logic [N_HARTS-1:0]    hart_halting,
    input  logic [N_TRIG_IN-1:0]  trig_in,
    input  logic                  abs_busy,
    output logic [N_HARTS-1:0]    halt_req,
    output logic [N_HARTS-1:0]    resume_req,
    output logic [N_TRIG_OUT-1:0] trig_out
);
    localparam int TI_BASE = N_HARTS;
    localparam int TO_BASE = N_HARTS + N_TRIG_IN;

    logic [N_MEM-1:0][GW-1:0] hgrp;
    logic [N_MEM-1:0][GW-1:0] rgrp;
    logic [N_HARTS-1:0]       halt_rise;
    logic [N_HARTS-1:0]       run_rise;
    logic [N_GROUPS-1:0]      hevt;
    logic [N_GROUPS-1:0]      rfire;

    hrg_cfg_regs #(.N_MEM(N_MEM), .GW(GW), .IW(IW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .kind   (cfg_kind),
        .idx    (cfg_idx),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .hgrp_o (hgrp),
        .rgrp_o (rgrp)
    );

    hrg_rise #(.W(N_HARTS)) u_halt_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (hart_halted),
        .rise  (halt_rise)
    );

    hrg_rise #(.W(N_HARTS)) u_run_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (hart_running),
        .rise  (run_rise)
    );

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        if (g == 0) begin : g_none
            assign hevt[g]  = 1'b0;
            assign rfire[g] = 1'b0;
        end else begin : g_live
            logic [N_HARTS-1:0]   hm;
            logic [N_HARTS-1:0]   rm;
            logic [N_TRIG_IN-1:0] htm;
            logic [N_TRIG_IN-1:0] rtm;
            logic                 revt;

            for (genvar h = 0; h < N_HARTS; h++) begin : g_hart
                assign hm[h] = (hgrp[h] == GW'(g));
                assign rm[h] = (rgrp[h] == GW'(g));
            end
            for (genvar t = 0; t < N_TRIG_IN; t++) begin : g_tin
                assign htm[t] = (hgrp[TI_BASE + t] == GW'(g));
                assign rtm[t] = (rgrp[TI_BASE + t] == GW'(g));
            end

            assign hevt[g] = (|(halt_rise & hm)) | (|(trig_in & htm));
            assign revt    = (|(run_rise & rm)) | (|(trig_in & rtm));

            hrg_resume_gate u_gate (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (revt),
                .busy  (abs_busy),
                .fire  (rfire[g])
            );
        end
    end

    for (genvar h = 0; h < N_HARTS; h++) begin : g_req
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                halt_req[h]   <= 1'b0;
                resume_req[h] <= 1'b0;
            end else begin
                halt_req[h]   <= hevt[hgrp[h]];
                resume_req[h] <= rfire[rgrp[h]] & ~hart_halting[h] & ~hart_running[h];
            end
        end
    end

    for (genvar t = 0; t < N_TRIG_OUT; t++) begin : g_tout
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                trig_out[t] <= 1'b0;
            end else begin
                trig_out[t] <= hevt[hgrp[TO_BASE + t]] | rfire[rgrp[TO_BASE + t]];
            end
        end
    end
endmodule

// File: rtl/hrg_chk.sv
module hrg_chk #(
    parameter int N_HARTS = 4,
    parameter int N_MEM   = 8,
    parameter int GW      = 2,
    parameter int IW      = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_HARTS-1:0]       hart_halting,
    input logic                     abs_busy,
    input logic [N_HARTS-1:0]       halt_req,
    input logic [N_HARTS-1:0]       resume_req,
    input logic                     cfg_we,
    input logic                     cfg_kind,
    input logic [IW-1:0]            cfg_idx,
    input logic [GW-1:0]            cfg_wdata,
    input logic [GW-1:0]            cfg_rdata,
    input logic [N_MEM-1:0][GW-1:0] hgrp,
    input logic [N_MEM-1:0][GW-1:0] rgrp
);
    for (genvar h = 0; h < N_HARTS; h++) begin : g_h
        p_halt_grp0_r7: assert property (@(posedge clk) disable iff (!rst_n)
            halt_req[h] |-> ($past(hgrp[h]) != '0));
        p_resume_grp0_r7: assert property (@(posedge clk) disable iff (!rst_n)
            resume_req[h] |-> ($past(rgrp[h]) != '0));
        p_skip_halting_r6: assert property (@(posedge clk) disable iff (!rst_n)
            resume_req[h] |-> !$past(hart_halting[h]));
    end

    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|resume_req) |-> !$past(abs_busy));

    p_cfg_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (32'(cfg_idx) < N_MEM)) |=>
        ((cfg_idx != $past(cfg_idx)) || (cfg_kind != $past(cfg_kind)) ||
         (cfg_rdata == $past(cfg_wdata))));
endmodule

bind halt_resume_grouper hrg_chk #(
    .N_HARTS (N_HARTS),
    .N_MEM   (N_MEM),
    .GW      (GW),
    .IW      (IW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hart_halting (hart_halting),
    .abs_busy     (abs_busy),
    .halt_req     (halt_req),
    .resume_req   (resume_req),
    .cfg_we       (cfg_we),
    .cfg_kind     (cfg_kind),
    .cfg_idx      (cfg_idx),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .hgrp         (hgrp),
    .rgrp         (rgrp)
);

// File: tb/halt_resume_grouper_tb.sv
`timescale 1ns/1ps
module halt_resume_grouper_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_kind = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [1:0] cfg_wdata = '0;
    logic [1:0] cfg_rdata;
    logic [3:0] hart_halted = '0;
    logic [3:0] hart_running = '0;
    logic [3:0] hart_halting = '0;
    logic [1:0] trig_in = '0;
    logic       abs_busy = 1'b0;
    logic [3:0] halt_req;
    logic [3:0] resume_req;
    logic [1:0] trig_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    halt_resume_grouper u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_kind (cfg_kind), .cfg_idx (cfg_idx),
        .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .hart_halted (hart_halted), .hart_running (hart_running),
        .hart_halting (hart_halting), .trig_in (trig_in), .abs_busy (abs_busy),
        .halt_req (halt_req), .resume_req (resume_req), .trig_out (trig_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg_wr(input logic k, input int idx, input int val);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = 3'(idx); cfg_wdata = 2'(val);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic k, input int idx, input int exp);
        cfg_kind = k; cfg_idx = 3'(idx);
        #1;
        chk(req, {6'd0, cfg_rdata}, 8'(exp));
    endtask

    task automatic quiet(input string req);
        chk(req, {halt_req, resume_req}, 8'h00);
        chk(req, {6'd0, trig_out}, 8'h00);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hg[4];
        int rg[4];
        int g, hp;
        logic [3:0] exp_h, exp_r;
        logic [1:0] exp_t;

        // R1: reset state
        repeat (3) tick();
        quiet("R1 in reset");
        rst_n = 1'b1;
        tick();
        quiet("R1 after reset");
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 8; i++) rd("R1 readback", k[0], i, 0);

        // R10: every entry stores and reads back its own value
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 8; i++) cfg_wr(k[0], i, (k * 3 + i) & 3);
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 8; i++) rd("R10 readback", k[0], i, (k * 3 + i) & 3);
        quiet("R9 after config writes");

        // fixed trigger assignments: inputs ungrouped, outputs halt {1,2} resume {3,0}
        cfg_wr(1'b0, 4, 0); cfg_wr(1'b0, 5, 0);
        cfg_wr(1'b1, 4, 0); cfg_wr(1'b1, 5, 0);
        cfg_wr(1'b0, 6, 1); cfg_wr(1'b0, 7, 2);
        cfg_wr(1'b1, 6, 3); cfg_wr(1'b1, 7, 0);
        for (int h = 0; h < 4; h++) cfg_wr(1'b1, h, 0);

        // R2, R7, R8, R11: sweep of all halt-group assignments
        for (int c = 0; c < 256; c++) begin
            for (int h = 0; h < 4; h++) begin
                hg[h] = (c >> (2 * h)) & 3;
                cfg_wr(1'b0, h, hg[h]);
            end
            for (int s = 0; s < 4; s++) begin
                g = hg[s];
                exp_h = '0;
                for (int h = 0; h < 4; h++) if (g != 0 && hg[h] == g) exp_h[h] = 1'b1;
                exp_t = (g == 1) ? 2'b01 : (g == 2) ? 2'b10 : 2'b00;
                hart_halted = 4'(1 << s);
                tick();
                chk(g == 0 ? "R7 halt group 0" : "R2 halt spread", {4'd0, halt_req}, {4'd0, exp_h});
                chk("R8 trig_out on halt", {6'd0, trig_out}, {6'd0, exp_t});
                tick();
                chk("R11 held halted level", {4'd0, halt_req}, 8'h00);
                hart_halted = '0;
                tick();
            end
        end

        for (int h = 0; h < 4; h++) cfg_wr(1'b0, h, 0);

        // R4, R6, R7, R8: sweep of all resume-group assignments
        for (int c = 0; c < 256; c++) begin
            for (int h = 0; h < 4; h++) begin
                rg[h] = (c >> (2 * h)) & 3;
                cfg_wr(1'b1, h, rg[h]);
            end
            for (int s = 0; s < 4; s++) begin
                hp = (c * 5 + s * 3) & 15;
                hart_halting = 4'(hp);
                tick();
                g = rg[s];
                exp_r = '0;
                for (int h = 0; h < 4; h++)
                    if (g != 0 && rg[h] == g && h != s && !hp[h]) exp_r[h] = 1'b1;
                exp_t = (g == 3) ? 2'b01 : 2'b00;
                hart_running = 4'(1 << s);
                tick();
                chk(g == 0 ? "R7 resume group 0" : "R4 R6 resume spread", {4'd0, resume_req}, {4'd0, exp_r});
                chk("R8 trig_out on resume", {6'd0, trig_out}, {6'd0, exp_t});
                tick();
                chk("R11 held running level", {4'd0, resume_req}, 8'h00);
                hart_running = '0;
                hart_halting = '0;
                tick();
            end
        end

        // R3 and R5: incoming trigger resume under a busy command
        cfg_wr(1'b1, 0, 2); cfg_wr(1'b1, 1, 2); cfg_wr(1'b1, 2, 1); cfg_wr(1'b1, 3, 0);
        cfg_wr(1'b1, 4, 2);
        abs_busy = 1'b1;
        trig_in = 2'b01;
        tick();
        trig_in = 2'b00;
        chk("R5 held while busy", {4'd0, resume_req}, 8'h00);
        tick();
        chk("R5 held while busy", {4'd0, resume_req}, 8'h00);
        tick();
        chk("R5 held while busy", {4'd0, resume_req}, 8'h00);
        abs_busy = 1'b0;
        tick();
        chk("R5 R3 released after busy", {4'd0, resume_req}, 8'h03);
        tick();
        chk("R5 single pulse", {4'd0, resume_req}, 8'h00);
        chk("R3 trigger did not halt", {4'd0, halt_req}, 8'h00);

        // R3: incoming trigger in a halt group
        cfg_wr(1'b0, 0, 1); cfg_wr(1'b0, 1, 2); cfg_wr(1'b0, 2, 1); cfg_wr(1'b0, 3, 1);
        cfg_wr(1'b0, 5, 1);
        trig_in = 2'b10;
        tick();
        trig_in = 2'b00;
        chk("R3 trigger halt spread", {4'd0, halt_req}, 8'h0D);
        chk("R3 R8 trig_out on trigger", {6'd0, trig_out}, 8'h01);
        tick();
        quiet("R3 pulse ends");

        // R9: joining a group never halts or resumes by itself
        for (int h = 0; h < 4; h++) begin cfg_wr(1'b0, h, 0); cfg_wr(1'b1, h, 0); end
        hart_halted = 4'b0001;
        hart_running = 4'b0100;
        tick();
        quiet("R9 group 0 edges");
        cfg_wr(1'b0, 0, 3);
        cfg_wr(1'b0, 1, 3);
        cfg_wr(1'b1, 2, 3);
        cfg_wr(1'b1, 3, 3);
        quiet("R9 after join");
        tick();
        quiet("R9 after join");
        hart_halted = '0;
        hart_running = '0;
        tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule